// File: doc/BRIEF.md
# Mailbox Status and Interrupt Controller

This block keeps the status of a mailbox shared by a local CPU and an external host bus, and raises the interrupt requests that go with it. The CPU sees two byte-wide registers on its register bus: an enable register that switches each mailbox source on or off, and a read-only status register. Three sources are tracked. The receive buffer can be full or empty. The transmit buffer can be empty or full. The memory channel reports a two-bit transfer state.

The host side is seen only through strobes. A host write into the receive buffer marks it full. A host read of the transmit buffer marks it empty. Start, access-in-progress and done signals drive the memory channel state. The CPU's own buffer accesses clear the flags as a side effect: reading the shared buffer register clears receive-full, and writing it clears transmit-empty. A source whose enable bit is low holds its status at the idle value and drops its interrupt. When a host configuration input is high and the host select pin is high, the host bus can read the status register.

The data buffers, the transfer engine and the host bus timing are outside this block.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: After reset, the enable register (offset 0x30) and the status register (offset 0x31) both read 0x00, and all three interrupt outputs are low.
- R2: A CPU write to offset 0x30 stores bits 2:0 (bit 0 receive, bit 1 transmit, bit 2 memory channel), and bits 7:3 read back as 0. CPU writes to 0x31 have no effect on the status. A read of any other offset returns 0x00.
- R3: Status bit 0 (receive full) becomes 1 in the cycle after a host receive-buffer write strobe while enable bit 0 is 1. It becomes 0 after a CPU buffer read while enable bit 0 is 1. It reads 0 whenever enable bit 0 is 0.
- R4: Status bit 1 (transmit empty) becomes 1 in the cycle after a host transmit-buffer read strobe while enable bit 1 is 1. It becomes 0 after a CPU buffer write while enable bit 1 is 1. It reads 0 whenever enable bit 1 is 0.
- R5: When a host set strobe and the CPU clear access for the same flag arrive in the same cycle, the flag ends up set.
- R6: Status bits 3:2 encode the memory channel as 00 stopped, 01 running without host access, 10 running with host access, and 11 ended. A start pulse moves 00 or 11 to 01. While running, the access input selects 10 or 01. A done pulse while running moves the state to 11, ahead of the access input. State 11 holds until the next start.
- R7: While enable bit 2 is 0, status bits 3:2 read 00 and start pulses have no effect. Clearing the bit leaves the state 00 when the bit is set again.
- R8: Each interrupt output equals its enable bit ANDed with its condition: receive full, transmit empty, or memory channel state 11.
- R9: The host data output carries the status register when both the host read configuration input and the host select pin are high, and 0x00 otherwise. Status bits 7:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_sel | input | 1 | CPU register access valid |
| cpu_we | input | 1 | CPU register write (with cpu_sel) |
| cpu_addr | input | 8 | CPU register offset |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data (combinational) |
| cpu_buf_rd | input | 1 | CPU reads the shared buffer register |
| cpu_buf_wr | input | 1 | CPU writes the shared buffer register |
| host_rx_wr | input | 1 | Host write strobe into the receive buffer |
| host_tx_rd | input | 1 | Host read strobe of the transmit buffer |
| mch_start | input | 1 | Memory channel operation start pulse |
| mch_access | input | 1 | Memory channel host access in progress (level) |
| mch_done | input | 1 | Memory channel operation end pulse |
| host_rd_cfg | input | 1 | Allows the host to read the status register |
| host_sel | input | 1 | Host status read select pin |
| host_rdata | output | 8 | Status as seen by the host |
| irq_rx | output | 1 | Receive buffer full interrupt request |
| irq_tx | output | 1 | Transmit buffer empty interrupt request |
| irq_mch | output | 1 | Memory channel end interrupt request |

## Verification
The assertions assume that every strobe and pulse input is clean and synchronous to clk. They assume reset is asserted at the start of time. They do not assume that set and clear strobes are mutually exclusive; the set-wins rule covers that case. The bench drives all inputs just after the falling edge and holds each pulse for exactly one clock. It sweeps every combination of enable, prior flag value, set and clear for both buffer flags. It walks the memory channel through every state edge, with the enable bit both high and low.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;

    localparam int unsigned MBX_SRC_N = 3;
    localparam int unsigned SRC_RX    = 0;
    localparam int unsigned SRC_TX    = 1;
    localparam int unsigned SRC_MC    = 2;

    typedef enum logic [1:0] {
        MCH_STOP = 2'b00,
        MCH_RUN  = 2'b01,
        MCH_XFER = 2'b10,
        MCH_END  = 2'b11
    } mch_state_e;

    typedef struct packed {
        logic [MBX_SRC_N-1:0] en;
    } ctrl_st_t;

    typedef struct packed {
        logic flag;
    } flag_st_t;

    typedef struct packed {
        mch_state_e st;
    } mch_st_t;

endpackage

// File: rtl/mbox_flag.sv
module mbox_flag
    import mbox_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    flag_st_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (!en_i) begin
            nxt_d.flag = 1'b0;
        end else if (set_i) begin
            nxt_d.flag = 1'b1;
        end else if (clr_i) begin
            nxt_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign flag_o = en_i & cur_q.flag;

    // R3 and R4: a disabled source leaves the flag cleared
    p_off_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !cur_q.flag);

    // R5: set wins over a simultaneous clear
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && set_i |=> cur_q.flag);

    // R4: a clear on its own empties the flag
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && clr_i && !set_i |=> !cur_q.flag);

endmodule

// File: rtl/mbox_mch.sv
module mbox_mch
    import mbox_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       start_i,
    input  logic       access_i,
    input  logic       done_i,
    output logic [1:0] code_o,
    output logic       end_o
);

    mch_st_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (!en_i) begin
            nxt_d.st = MCH_STOP;
        end else begin
            unique case (cur_q.st)
                MCH_STOP: if (start_i) nxt_d.st = MCH_RUN;
                MCH_RUN, MCH_XFER: begin
                    if (done_i)        nxt_d.st = MCH_END;
                    else if (access_i) nxt_d.st = MCH_XFER;
                    else               nxt_d.st = MCH_RUN;
                end
                MCH_END:  if (start_i) nxt_d.st = MCH_RUN;
                default:  nxt_d.st = MCH_STOP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: MCH_STOP};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign code_o = en_i ? cur_q.st : MCH_STOP;
    assign end_o  = en_i && (cur_q.st == MCH_END);

    // R6: done while running always reaches the end state
    p_done_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && (cur_q.st == MCH_RUN || cur_q.st == MCH_XFER) && done_i
        |=> cur_q.st == MCH_END);

    // R6: end state is sticky until a new start
    p_end_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && cur_q.st == MCH_END && !start_i |=> cur_q.st == MCH_END);

    // R7: disabling returns the channel to stopped
    p_off_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> cur_q.st == MCH_STOP);

endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
    import mbox_irq_pkg::*;
#(
    parameter int unsigned          ADDR_W    = 8,
    parameter int unsigned          DATA_W    = 8,
    parameter logic [ADDR_W-1:0]    EN_ADDR   = 8'h30,
    parameter logic [ADDR_W-1:0]    STAT_ADDR = 8'h31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              cpu_buf_rd,
    input  logic              cpu_buf_wr,
    input  logic              host_rx_wr,
    input  logic              host_tx_rd,
    input  logic              mch_start,
    input  logic              mch_access,
    input  logic              mch_done,
    input  logic              host_rd_cfg,
    input  logic              host_sel,
    output logic [DATA_W-1:0] host_rdata,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_mch
);

    localparam int unsigned MC_LSB = MBX_SRC_N - 1;

    ctrl_st_t    ctl_q, ctl_d;
    logic        rx_full, tx_empty, mch_end;
    logic [1:0]  mch_code;
    logic [DATA_W-1:0] status;

    always_comb begin
        ctl_d = ctl_q;
        if (cpu_sel && cpu_we && cpu_addr == EN_ADDR) begin
            ctl_d.en = cpu_wdata[MBX_SRC_N-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    mbox_flag u_rx_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (ctl_q.en[SRC_RX]),
        .set_i  (host_rx_wr),
        .clr_i  (cpu_buf_rd),
        .flag_o (rx_full)
    );

    mbox_flag u_tx_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (ctl_q.en[SRC_TX]),
        .set_i  (host_tx_rd),
        .clr_i  (cpu_buf_wr),
        .flag_o (tx_empty)
    );

    mbox_mch u_mch (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (ctl_q.en[SRC_MC]),
        .start_i  (mch_start),
        .access_i (mch_access),
        .done_i   (mch_done),
        .code_o   (mch_code),
        .end_o    (mch_end)
    );

    always_comb begin
        status                     = '0;
        status[SRC_RX]             = rx_full;
        status[SRC_TX]             = tx_empty;
        status[MC_LSB+1:MC_LSB]    = mch_code;
    end

    always_comb begin
        cpu_rdata = '0;
        if (cpu_addr == EN_ADDR) begin
            cpu_rdata[MBX_SRC_N-1:0] = ctl_q.en;
        end else if (cpu_addr == STAT_ADDR) begin
            cpu_rdata = status;
        end
    end

    assign host_rdata = (host_rd_cfg && host_sel) ? status : '0;
    assign irq_rx     = rx_full;
    assign irq_tx     = tx_empty;
    assign irq_mch    = mch_end;

    // R8: no interrupt request from a disabled source
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_rx && !ctl_q.en[SRC_RX]) && !(irq_tx && !ctl_q.en[SRC_TX])
        && !(irq_mch && !ctl_q.en[SRC_MC]));

    // R9: host sees nothing unless both select conditions hold
    p_host_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd_cfg && host_sel) |-> host_rdata == '0);

    // R2: reserved enable bits never read back as 1
    p_en_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr == EN_ADDR |-> cpu_rdata[DATA_W-1:MBX_SRC_N] == '0);

endmodule

// File: tb/mbox_irq_ctrl_bench.sv
module mbox_irq_ctrl_bench;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_sel = 0, cpu_we = 0;
    logic [7:0] cpu_addr = 8'h00, cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata, host_rdata;
    logic       cpu_buf_rd = 0, cpu_buf_wr = 0, host_rx_wr = 0, host_tx_rd = 0;
    logic       mch_start = 0, mch_access = 0, mch_done = 0;
    logic       host_rd_cfg = 0, host_sel = 0;
    logic       irq_rx, irq_tx, irq_mch;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    mbox_irq_ctrl u_mbox_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_buf_rd(cpu_buf_rd), .cpu_buf_wr(cpu_buf_wr),
        .host_rx_wr(host_rx_wr), .host_tx_rd(host_tx_rd),
        .mch_start(mch_start), .mch_access(mch_access), .mch_done(mch_done),
        .host_rd_cfg(host_rd_cfg), .host_sel(host_sel), .host_rdata(host_rdata),
        .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_mch(irq_mch)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
        cpu_sel = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
        step();
        cpu_sel = 0; cpu_we = 0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [7:0] d);
        cpu_addr = a;
        #1;
        d = cpu_rdata;
    endtask

    task automatic pulse(input logic rxw, input logic txr, input logic brd, input logic bwr);
        host_rx_wr = rxw; host_tx_rd = txr; cpu_buf_rd = brd; cpu_buf_wr = bwr;
        step();
        host_rx_wr = 0; host_tx_rd = 0; cpu_buf_rd = 0; cpu_buf_wr = 0;
    endtask

    task automatic mch_pulse(input logic st, input logic dn);
        mch_start = st; mch_done = dn;
        step();
        mch_start = 0; mch_done = 0;
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic       exp_f;
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();

        // R1: reset values
        reg_rd(8'h30, rd); chk("R1 enable reset", rd, 8'h00);
        reg_rd(8'h31, rd); chk("R1 status reset", rd, 8'h00);
        chk("R1 irqs reset", {5'b0, irq_mch, irq_tx, irq_rx}, 8'h00);

        // R2: every enable write value
        for (int v = 0; v < 256; v++) begin
            reg_wr(8'h30, 8'(v));
            reg_rd(8'h30, rd);
            chk("R2 enable readback", rd, 8'(v) & 8'h07);
        end
        reg_wr(8'h30, 8'h00);
        reg_rd(8'h12, rd); chk("R2 unmapped offset", rd, 8'h00);

        // R3, R5: receive flag sweep over enable, prior, set, clear
        for (int e = 0; e < 2; e++)
            for (int p = 0; p < 2; p++)
                for (int s = 0; s < 2; s++)
                    for (int c = 0; c < 2; c++) begin
                        reg_wr(8'h30, 8'h01);
                        if (p == 1) pulse(1, 0, 0, 0); else pulse(0, 0, 1, 0);
                        reg_wr(8'h30, 8'(e));
                        pulse(s[0], 0, c[0], 0);
                        exp_f = (e == 1) && (s == 1 || (p == 1 && c == 0));
                        reg_rd(8'h31, rd);
                        chk("R3/R5 rx full bit", rd, {7'b0, exp_f});
                        chk("R8 irq_rx", {7'b0, irq_rx}, {7'b0, exp_f});
                    end

        // R4, R5: transmit flag sweep
        for (int e = 0; e < 2; e++)
            for (int p = 0; p < 2; p++)
                for (int s = 0; s < 2; s++)
                    for (int c = 0; c < 2; c++) begin
                        reg_wr(8'h30, 8'h02);
                        if (p == 1) pulse(0, 1, 0, 0); else pulse(0, 0, 0, 1);
                        reg_wr(8'h30, 8'(e << 1));
                        pulse(0, s[0], 0, c[0]);
                        exp_f = (e == 1) && (s == 1 || (p == 1 && c == 0));
                        reg_rd(8'h31, rd);
                        chk("R4/R5 tx empty bit", rd, {6'b0, exp_f, 1'b0});
                        chk("R8 irq_tx", {7'b0, irq_tx}, {7'b0, exp_f});
                    end

        // R7: disabled memory channel ignores start
        reg_wr(8'h30, 8'h00);
        mch_pulse(1, 0);
        reg_rd(8'h31, rd); chk("R7 disabled start ignored", rd, 8'h00);

        // R6: memory channel walk
        reg_wr(8'h30, 8'h04);
        reg_rd(8'h31, rd); chk("R6 stopped", rd, 8'h00);
        mch_pulse(0, 1);
        reg_rd(8'h31, rd); chk("R6 done while stopped ignored", rd, 8'h00);
        mch_pulse(1, 0);
        reg_rd(8'h31, rd); chk("R6 run", rd, 8'h04);
        mch_access = 1; step();
        reg_rd(8'h31, rd); chk("R6 access", rd, 8'h08);
        mch_access = 0; step();
        reg_rd(8'h31, rd); chk("R6 back to run", rd, 8'h04);
        chk("R8 irq_mch low while running", {7'b0, irq_mch}, 8'h00);
        mch_pulse(0, 1);
        reg_rd(8'h31, rd); chk("R6 end", rd, 8'h0C);
        chk("R8 irq_mch on end", {7'b0, irq_mch}, 8'h01);
        step();
        reg_rd(8'h31, rd); chk("R6 end holds", rd, 8'h0C);
        mch_pulse(1, 0);
        reg_rd(8'h31, rd); chk("R6 restart from end", rd, 8'h04);
        mch_access = 1; step();
        mch_pulse(0, 1);
        reg_rd(8'h31, rd); chk("R6 done beats access", rd, 8'h0C);
        mch_access = 0;

        // R7: disable drops state and interrupt, re-enable starts stopped
        reg_wr(8'h30, 8'h00);
        reg_rd(8'h31, rd); chk("R7 disabled reads stopped", rd, 8'h00);
        chk("R7 irq_mch dropped", {7'b0, irq_mch}, 8'h00);
        reg_wr(8'h30, 8'h04);
        reg_rd(8'h31, rd); chk("R7 re-enable stopped", rd, 8'h00);

        // R2: status writes ignored; R9: host read port
        reg_wr(8'h30, 8'h07);
        pulse(1, 1, 0, 0);
        reg_wr(8'h31, 8'hF0);
        reg_rd(8'h31, rd); chk("R2 status write ignored", rd, 8'h03);
        for (int m = 0; m < 4; m++) begin
            host_rd_cfg = m[0]; host_sel = m[1];
            #1;
            chk("R9 host status read", host_rdata, (m == 3) ? 8'h03 : 8'h00);
        end
        host_rd_cfg = 0; host_sel = 0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule